// File: doc/BRIEF.md
# Endian-Selectable Byte-Packing Receive FIFO

This block takes bytes from a serial receiver, joins each pair into one 16-bit word and queues the words in a small FIFO. A host reads them through a read-only 16-bit data port and a one-cycle read strobe. An order input chooses the half of the word that the first byte of a pair goes into. When a transfer ends on an odd byte, an end-of-transfer pulse flushes that byte as a partial word, placed in the half that the order gives.

A two-state machine builds the words. In `PK_IDLE` no byte is pending. The first byte of a pair, together with the order in force at that moment, is latched on the transition `PK_IDLE -> PK_HALF` (named *take_first*). In `PK_HALF` one of two transitions returns to `PK_IDLE` and pushes a word:
- *complete_pair* when a second byte arrives;
- *flush_lone* when end-of-transfer arrives with no byte.

A byte that arrives together with end-of-transfer while in `PK_IDLE` stays in `PK_IDLE` and is pushed at once as a lone word (*lone_direct*). Soft reset forces `PK_IDLE` from either state (*abort*).

Status outputs report the following:
- empty and full;
- a data-request flag that tells the host a word is waiting;
- a sticky overrun flag.

Top module: `rx_pack_fifo`

## Requirements
- R1: With `order_sel`=0 (big-endian, the reset default), the first byte of a pair is placed in `rd_data[15:8]` and the second in `rd_data[7:0]`.
- R2: With `order_sel`=1 (little-endian), the first byte of a pair is placed in `rd_data[7:0]` and the second in `rd_data[15:8]`.
- R3: `xfer_end` with one byte pending pushes a partial word at that edge. In big-endian the byte is in bits 15:8, and in little-endian it is in bits 7:0. The empty half reads as zero. A byte that arrives together with `xfer_end` and no byte pending is pushed the same way. `xfer_end` with nothing pending and no byte pushes nothing.
- R4: `order_sel` is sampled with the first byte of each pair. A change between the two bytes of a pair does not alter that word; it applies from the next pair.
- R5: `rd_data` shows the oldest stored word without a strobe. Each `rd_en` pulse while not empty removes that word, and words leave in arrival order.
- R6: While `empty` is 1, `rd_data` reads 0x0000, and `rd_en` changes neither the stored words nor the flags.
- R7: `empty`=1 with no words stored. `full`=1 with DEPTH words stored. `data_req` equals the inverse of `empty`.
- R8: A word completed while `full` is 1 is dropped, and `overrun` rises. `overrun` then stays 1 until `rst_n` or `soft_rst` clears it.
- R9: A cycle with `soft_rst`=1 empties the FIFO, discards any pending byte, clears `overrun` and `rd_data`, and ignores the byte inputs in that cycle. After `rst_n` the block is in the same state.
- R10: A word is readable, and the flags reflect it, right after the clock edge that samples the byte or end pulse that completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous clear of FIFO, packer and overrun |
| byte_valid | input | 1 | A received byte is on `byte_in` this cycle |
| byte_in | input | 8 | Received byte |
| xfer_end | input | 1 | Transfer has ended; flush a pending odd byte |
| order_sel | input | 1 | 0 = first byte high, 1 = first byte low |
| rd_en | input | 1 | Host read strobe, one cycle per word |
| rd_data | output | 16 | Oldest stored word, zero when empty |
| empty | output | 1 | No word stored |
| full | output | 1 | DEPTH words stored |
| data_req | output | 1 | A word is ready for the host |
| overrun | output | 1 | Sticky: a completed word was dropped |

## Verification
Every result of this block is due one edge after its cause. A word that is completed by a second byte or flushed by `xfer_end` appears on `rd_data` and clears `empty` right after the edge that samples that input. A read strobe or soft reset removes words at the edge it is sampled, and `overrun` rises at the same edge as the dropped push. The bench drives each stimulus for exactly one cycle starting at a falling edge and checks the outputs at the next falling edge, so each expected value is compared half a cycle after the edge that produced it.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;

    typedef enum logic {
        ORD_BIG    = 1'b0,
        ORD_LITTLE = 1'b1
    } rxpk_order_e;

    typedef enum logic [1:0] {
        PK_IDLE = 2'd0,
        PK_HALF = 2'd1
    } rxpk_state_e;

    // Place two bytes into a word; the first byte's half depends on order.
    function automatic logic [15:0] pack_pair(rxpk_order_e ord,
                                              logic [7:0] first,
                                              logic [7:0] second);
        return (ord == ORD_LITTLE) ? {second, first} : {first, second};
    endfunction

    // A lone byte is a pair whose second byte is zero.
    function automatic logic [15:0] pack_lone(rxpk_order_e ord, logic [7:0] first);
        return pack_pair(ord, first, 8'h00);
    endfunction

endpackage

// File: rtl/rxpk_packer.sv
module rxpk_packer
    import rxpk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        byte_valid,
    input  logic [7:0]  byte_in,
    input  logic        xfer_end,
    input  logic        order_sel,
    output logic        push,
    output logic [15:0] push_word
);

    rxpk_state_e state_q, state_d;
    logic [7:0]  hold_q,  hold_d;
    rxpk_order_e mode_q,  mode_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PK_IDLE;
            hold_q  <= 8'h00;
            mode_q  <= ORD_BIG;
        end else if (soft_rst) begin
            state_q <= PK_IDLE;
            hold_q  <= 8'h00;
            mode_q  <= ORD_BIG;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
            mode_q  <= mode_d;
        end
    end

    // Transitions and outputs
    always_comb begin
        state_d   = state_q;
        hold_d    = hold_q;
        mode_d    = mode_q;
        push      = 1'b0;
        push_word = 16'h0000;
        unique case (state_q)
            PK_IDLE: begin
                if (byte_valid && xfer_end) begin
                    push      = 1'b1;
                    push_word = pack_lone(rxpk_order_e'(order_sel), byte_in);
                end else if (byte_valid) begin
                    hold_d  = byte_in;
                    mode_d  = rxpk_order_e'(order_sel);
                    state_d = PK_HALF;
                end
            end
            PK_HALF: begin
                if (byte_valid) begin
                    push      = 1'b1;
                    push_word = pack_pair(mode_q, hold_q, byte_in);
                    hold_d    = 8'h00;
                    state_d   = PK_IDLE;
                end else if (xfer_end) begin
                    push      = 1'b1;
                    push_word = pack_lone(mode_q, hold_q);
                    hold_d    = 8'h00;
                    state_d   = PK_IDLE;
                end
            end
            default: begin
                state_d = PK_IDLE;
            end
        endcase
        if (soft_rst) begin
            push = 1'b0;
        end
    end

endmodule

// File: rtl/rxpk_fifo.sv
module rxpk_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_word,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic             dropped
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST  = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CMAX  = CNT_W'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             accept, take;

    assign empty   = (count == '0);
    assign full    = (count == CMAX);
    assign accept  = push && !full;
    assign take    = pop && !empty;
    assign dropped = push && full;
    assign head    = empty ? '0 : mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (accept) begin
                mem[wr_ptr] <= push_word;
                wr_ptr      <= bump(wr_ptr);
            end
            if (take) begin
                rd_ptr <= bump(rd_ptr);
            end
            unique case ({accept, take})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/rxpk_status.sv
module rxpk_status (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic dropped,
    input  logic empty,
    output logic overrun,
    output logic data_req
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overrun <= 1'b0;
        end else if (soft_rst) begin
            overrun <= 1'b0;
        end else if (dropped) begin
            overrun <= 1'b1;
        end
    end

    assign data_req = !empty;

endmodule

// File: rtl/rx_pack_fifo.sv
module rx_pack_fifo #(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        byte_valid,
    input  logic [7:0]  byte_in,
    input  logic        xfer_end,
    input  logic        order_sel,
    input  logic        rd_en,
    output logic [15:0] rd_data,
    output logic        empty,
    output logic        full,
    output logic        data_req,
    output logic        overrun
);

    logic        push;
    logic [15:0] push_word;
    logic        dropped;

    rxpk_packer u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .byte_valid (byte_valid),
        .byte_in    (byte_in),
        .xfer_end   (xfer_end),
        .order_sel  (order_sel),
        .push       (push),
        .push_word  (push_word)
    );

    rxpk_fifo #(.DEPTH(DEPTH), .WIDTH(16)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (soft_rst),
        .push      (push),
        .push_word (push_word),
        .pop       (rd_en && !soft_rst),
        .head      (rd_data),
        .empty     (empty),
        .full      (full),
        .dropped   (dropped)
    );

    rxpk_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .dropped  (dropped),
        .empty    (empty),
        .overrun  (overrun),
        .data_req (data_req)
    );

endmodule

// File: rtl/rxpk_chk.sv
module rxpk_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        soft_rst,
    input logic        byte_valid,
    input logic        xfer_end,
    input logic        rd_en,
    input logic [15:0] rd_data,
    input logic        empty,
    input logic        full,
    input logic        overrun
);

    p_flags_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    p_empty_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (rd_data == 16'h0000));

    p_empty_read_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !byte_valid && !xfer_end && !soft_rst) |=> empty);

    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !soft_rst) |=> overrun);

    p_overrun_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(full));

    p_full_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en && !soft_rst) |=> full);

    p_soft_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (empty && !overrun));

endmodule

bind rx_pack_fifo rxpk_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .byte_valid (byte_valid),
    .xfer_end   (xfer_end),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .empty      (empty),
    .full       (full),
    .overrun    (overrun)
);

// File: tb/rx_pack_fifo_test.sv
module rx_pack_fifo_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic        xfer_end = 1'b0;
    logic        order_sel = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        empty, full, data_req, overrun;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rx_pack_fifo #(.DEPTH(4)) uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .byte_valid(byte_valid), .byte_in(byte_in), .xfer_end(xfer_end),
        .order_sel(order_sel), .rd_en(rd_en), .rd_data(rd_data),
        .empty(empty), .full(full), .data_req(data_req), .overrun(overrun)
    );

    // {order, first byte, second byte, expected word}
    localparam logic [32:0] VEC [6] = '{
        {1'b0, 8'hA1, 8'hB2, 16'hA1B2},
        {1'b1, 8'hA1, 8'hB2, 16'hB2A1},
        {1'b0, 8'h00, 8'hFF, 16'h00FF},
        {1'b1, 8'h00, 8'hFF, 16'hFF00},
        {1'b0, 8'h5A, 8'hC3, 16'h5AC3},
        {1'b1, 8'h7E, 8'h01, 16'h017E}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input logic last);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_in    = b;
        xfer_end   = last;
        @(negedge clk);
        byte_valid = 1'b0;
        xfer_end   = 1'b0;
    endtask

    task automatic pulse_end();
        @(negedge clk);
        xfer_end = 1'b1;
        @(negedge clk);
        xfer_end = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_soft();
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired before the run completed");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 / R7: state after reset
        check("R9 reset rd_data", rd_data, 16'h0000);
        check("R7 reset empty", {15'b0, empty}, 16'd1);
        check("R7 reset full", {15'b0, full}, 16'd0);
        check("R7 reset data_req", {15'b0, data_req}, 16'd0);
        check("R8 reset overrun", {15'b0, overrun}, 16'd0);

        // R1 / R2 / R10: vector table
        for (int i = 0; i < 6; i++) begin
            order_sel = VEC[i][32];
            send_byte(VEC[i][31:24], 1'b0);
            check("R10 no word after one byte", {15'b0, empty}, 16'd1);
            send_byte(VEC[i][23:16], 1'b0);
            check(VEC[i][32] ? "R2 little-endian pair" : "R1 big-endian pair",
                  rd_data, VEC[i][15:0]);
            check("R7 data_req with word", {15'b0, data_req}, 16'd1);
            do_read();
            check("R5 empty after read", {15'b0, empty}, 16'd1);
        end

        // R3: partial words
        order_sel = 1'b0;
        send_byte(8'h3C, 1'b0);
        pulse_end();
        check("R3 big-endian lone byte", rd_data, 16'h3C00);
        do_read();
        order_sel = 1'b1;
        send_byte(8'h3C, 1'b0);
        pulse_end();
        check("R3 little-endian lone byte", rd_data, 16'h003C);
        do_read();
        send_byte(8'hAB, 1'b1);
        check("R3 byte with end, nothing pending", rd_data, 16'h00AB);
        do_read();
        pulse_end();
        check("R3 end with nothing pending", {15'b0, empty}, 16'd1);

        // R4: order change in mid-pair
        order_sel = 1'b0;
        send_byte(8'h11, 1'b0);
        order_sel = 1'b1;
        send_byte(8'h22, 1'b0);
        check("R4 order held for pair", rd_data, 16'h1122);
        do_read();
        send_byte(8'h33, 1'b0);
        send_byte(8'h44, 1'b0);
        check("R4 new order on next pair", rd_data, 16'h4433);
        do_read();

        // R6: read while empty
        do_read();
        check("R6 empty read data", rd_data, 16'h0000);
        check("R6 empty read flag", {15'b0, empty}, 16'd1);
        order_sel = 1'b0;
        send_byte(8'h12, 1'b0);
        send_byte(8'h34, 1'b0);
        check("R6 pointers unchanged", rd_data, 16'h1234);
        do_read();
        check("R6 single word drained", {15'b0, empty}, 16'd1);

        // R7 / R8 / R5: fill, overrun, drain in order
        for (int w = 0; w < 4; w++) begin
            send_byte(8'(2 * w + 1), 1'b0);
            send_byte(8'(2 * w + 2), 1'b0);
        end
        check("R7 full at depth", {15'b0, full}, 16'd1);
        check("R8 no overrun yet", {15'b0, overrun}, 16'd0);
        send_byte(8'h09, 1'b0);
        send_byte(8'h0A, 1'b0);
        check("R8 overrun on drop", {15'b0, overrun}, 16'd1);
        for (int w = 0; w < 4; w++) begin
            check("R5 FIFO order", rd_data, {8'(2 * w + 1), 8'(2 * w + 2)});
            do_read();
        end
        check("R8 dropped word absent", {15'b0, empty}, 16'd1);
        check("R8 overrun sticky", {15'b0, overrun}, 16'd1);

        // R9: soft reset clears overrun, FIFO and pending byte
        send_byte(8'hEE, 1'b0);
        send_byte(8'hFF, 1'b0);
        send_byte(8'h55, 1'b0);
        pulse_soft();
        check("R9 soft reset empties", {15'b0, empty}, 16'd1);
        check("R9 soft reset overrun", {15'b0, overrun}, 16'd0);
        check("R9 soft reset rd_data", rd_data, 16'h0000);
        send_byte(8'h66, 1'b0);
        send_byte(8'h77, 1'b0);
        check("R9 pending byte discarded", rd_data, 16'h6677);
        do_read();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule